// File: doc/BRIEF.md
# Pixel Component Extractor

This block sits between a framebuffer fetch path and a display output stage. For each raw pixel word it receives, it pulls out a red, a green and a blue bit field and widens each one to an 8-bit component. Software sets the pixel size in bytes and, for each colour, the bit offset of the field, its length and a fallback value. Almost any packed RGB layout of one to four bytes per pixel can therefore be decoded without changing the hardware.

A colour takes its fallback value when its length is programmed as zero, when the pixel is outside the visible area, or when the fetch path flags an underrun. Setting the red fallback to 0xFF and the other fallbacks to 0x00 makes underruns show as solid red. Results are registered and appear one cycle after the input, together with a valid strobe.

Top module: `pxx_extract_top`

## Requirements
- R1: While reset is high, and after it, all three components and `out_valid` read zero. The configuration resets to one byte per pixel, and every colour has length 0 and fallback 0x00.
- R2: `out_valid` equals the `pix_valid` value of the previous clock cycle.
- R3: Components are loaded only on cycles where `pix_valid` is high. Otherwise they keep their last value.
- R4: A write to address 0 sets bytes per pixel minus one from `cfg_wdata[4:3]`. Raw word bits at or above 8 × bytes-per-pixel count as zero before any field is extracted.
- R5: Writes to addresses 1, 2 and 3 program red, green and blue. `cfg_wdata[23:16]` is the fallback, `[11:8]` is the field length and `[4:0]` is the offset of the field's lowest bit.
- R6: A colour whose length is 0 outputs its fallback value.
- R7: A pixel with `pix_visible` low outputs the fallback on all three colours.
- R8: A pixel with `pix_underrun` high outputs the fallback on all three colours, even when `pix_visible` is high.
- R9: A field of length L from 1 to 8 is placed in the top L output bits. Its bits are then repeated from the MSB downward to fill the lower bits: length 1 gives 0x00 or 0xFF, and length 3 with field 101b gives 0xB6.
- R10: A field longer than 8 bits outputs its 8 most significant bits.
- R11: Field bits that fall above bit 31 of the raw word read as zero.
- R12: A configuration write takes effect for pixels presented on the cycle after the write. A pixel presented on the write cycle itself uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address: 0 = format, 1 = red, 2 = green, 3 = blue |
| cfg_wdata | input | 32 | Configuration write data |
| pix_data | input | 32 | Raw pixel word |
| pix_valid | input | 1 | Raw pixel word is valid |
| pix_visible | input | 1 | Pixel lies inside the visible area |
| pix_underrun | input | 1 | Fetch path underran for this pixel |
| out_red | output | 8 | Red component |
| out_green | output | 8 | Green component |
| out_blue | output | 8 | Blue component |
| out_valid | output | 1 | Components valid |

## Verification
The directed patterns each target one rule. A 16-bit 5-6-5 layout with all-ones, pure-red and mid-grey words checks the per-colour offsets and the left-justified replication. A 1-byte setting with a field in the second byte checks the byte mask, because a wrong mask would leak nonzero bits. A 12-bit field and a field running past bit 31 separate clamping to the top bits from the zero fill above the word. Random configurations and pixels, with random visible and underrun flags, are compared against a bit-by-bit model; these exercise offset, length and fallback combinations that the directed cases miss.

// File: rtl/pxx_pkg.sv
package pxx_pkg;
    localparam int PIX_W   = 32;
    localparam int BYTES_W = 2;
    localparam int OFF_W   = 5;
    localparam int LEN_W   = 4;
    localparam int COMP_W  = 8;
    localparam int NCOMP   = 3;

    typedef struct packed {
        logic [COMP_W-1:0] dflt;
        logic [LEN_W-1:0]  len;
        logic [OFF_W-1:0]  off;
    } comp_sel_t;

    typedef enum logic [1:0] {
        ADR_FORMAT = 2'd0,
        ADR_RED    = 2'd1,
        ADR_GREEN  = 2'd2,
        ADR_BLUE   = 2'd3
    } cfg_adr_e;

    function automatic comp_sel_t sel_from_word(input logic [PIX_W-1:0] w);
        comp_sel_t s;
        s.dflt = w[23:16];
        s.len  = w[11:8];
        s.off  = w[4:0];
        return s;
    endfunction

    function automatic logic [PIX_W-1:0] byte_keep(input logic [BYTES_W-1:0] bm1);
        logic [PIX_W-1:0] m;
        m = '0;
        for (int b = 0; b < PIX_W/8; b++) begin
            if (b <= int'(bm1)) m[b*8 +: 8] = 8'hFF;
        end
        return m;
    endfunction

    // Widen a field to COMP_W bits: clamp long fields, replicate short ones.
    function automatic logic [COMP_W-1:0] pull_field(input logic [PIX_W-1:0] w,
                                                     input comp_sel_t s);
        logic [PIX_W-1:0]  f;
        logic [COMP_W-1:0] r;
        int                l;
        f = w >> s.off;
        l = int'(s.len);
        r = '0;
        if (l > COMP_W) begin
            r = COMP_W'(f >> (l - COMP_W));
        end else if (l > 0) begin
            for (int j = 0; j < COMP_W; j++) begin
                r[j] = f[l - 1 - ((COMP_W - 1 - j) % l)];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pxx_cfg_regs.sv
module pxx_cfg_regs
    import pxx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [1:0]         addr,
    input  logic [PIX_W-1:0]   wdata,
    output logic [BYTES_W-1:0] bytes_m1,
    output comp_sel_t          sel [NCOMP]
);
    logic wdata_unused;
    assign wdata_unused = ^{wdata[31:24], wdata[15:12], wdata[7:5]};

    always_ff @(posedge clk) begin
        if (rst) bytes_m1 <= '0;
        else if (we && addr == ADR_FORMAT) bytes_m1 <= wdata[4:3];
    end

    for (genvar i = 0; i < NCOMP; i++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst) sel[i] <= '0;
            else if (we && addr == 2'(i + 1)) sel[i] <= sel_from_word(wdata);
        end
    end

    // R4: the format setting moves only on a write to its address
    p_format_only_on_write_r4: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !(we && addr == ADR_FORMAT)) |-> $stable(bytes_m1));
endmodule

// File: rtl/pxx_lane.sv
module pxx_lane
    import pxx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  word,
    input  comp_sel_t         sel,
    input  logic              valid,
    input  logic              blank,
    output logic [COMP_W-1:0] comp
);
    always_ff @(posedge clk) begin
        if (rst) comp <= '0;
        else if (valid) comp <= (blank || sel.len == '0) ? sel.dflt : pull_field(word, sel);
    end

    // R6/R7/R8: fallback value on zero length, blanking or underrun
    p_fallback_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && valid && (blank || sel.len == '0)) |-> comp == $past(sel.dflt));

    // R3: no update without a valid pixel
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !valid) |-> $stable(comp));

    // R9: a one-bit field saturates to all zeros or all ones
    p_one_bit_r9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && valid && !blank && sel.len == 4'd1) |-> (comp == '0 || comp == '1));
endmodule

// File: rtl/pxx_extract_top.sv
module pxx_extract_top
    import pxx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic [31:0] pix_data,
    input  logic        pix_valid,
    input  logic        pix_visible,
    input  logic        pix_underrun,
    output logic [7:0]  out_red,
    output logic [7:0]  out_green,
    output logic [7:0]  out_blue,
    output logic        out_valid
);
    logic [BYTES_W-1:0] bytes_m1;
    comp_sel_t          sel [NCOMP];
    logic [PIX_W-1:0]   kept;
    logic               blank;
    logic [COMP_W-1:0]  comp [NCOMP];
    logic               live_q;

    pxx_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .bytes_m1(bytes_m1), .sel(sel)
    );

    assign kept  = pix_data & byte_keep(bytes_m1);
    assign blank = !pix_visible || pix_underrun;

    for (genvar i = 0; i < NCOMP; i++) begin : g_lane
        pxx_lane u_lane (
            .clk(clk), .rst(rst), .word(kept), .sel(sel[i]),
            .valid(pix_valid), .blank(blank), .comp(comp[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            live_q    <= 1'b0;
        end else begin
            out_valid <= pix_valid;
            live_q    <= 1'b1;
        end
    end

    assign out_red   = comp[0];
    assign out_green = comp[1];
    assign out_blue  = comp[2];

    // R2: output strobe trails the input strobe by one cycle
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        live_q |-> out_valid == $past(pix_valid));
endmodule

// File: tb/pxx_extract_top_tb.sv
module pxx_extract_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] pix_data;
    logic        pix_valid, pix_visible, pix_underrun;
    logic [7:0]  out_red, out_green, out_blue;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side copy of programmed state, kept from the writes it issues
    logic [1:0]  m_bm1;
    logic [31:0] m_sel [3];

    always #10 clk = ~clk;

    pxx_extract_top u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_data(pix_data), .pix_valid(pix_valid),
        .pix_visible(pix_visible), .pix_underrun(pix_underrun),
        .out_red(out_red), .out_green(out_green), .out_blue(out_blue),
        .out_valid(out_valid)
    );

    function automatic logic [7:0] model(input logic [31:0] w, input logic [1:0] bm1,
                                         input logic [31:0] s, input bit vis, input bit und);
        int l, off, nbits;
        logic [15:0] f;
        logic [7:0] r;
        l = int'(s[11:8]);
        off = int'(s[4:0]);
        nbits = (int'(bm1) + 1) * 8;
        if (l == 0 || !vis || und) return s[23:16];
        f = '0;
        for (int k = 0; k < l; k++) begin
            if (off + k < nbits) f[k] = w[off + k];
        end
        if (l > 8) begin
            for (int j = 0; j < 8; j++) r[j] = f[l - 8 + j];
        end else begin
            for (int j = 0; j < 8; j++) r[j] = f[l - 1 - ((7 - j) % l)];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        if (a == 0) m_bm1 = d[4:3]; else m_sel[a-1] = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic pix(input string req, input logic [31:0] w, input bit vis, input bit und);
        logic [7:0] er, eg, eb;
        @(negedge clk);
        pix_data = w; pix_valid = 1; pix_visible = vis; pix_underrun = und;
        er = model(w, m_bm1, m_sel[0], vis, und);
        eg = model(w, m_bm1, m_sel[1], vis, und);
        eb = model(w, m_bm1, m_sel[2], vis, und);
        @(negedge clk);
        pix_valid = 0;
        check(req, {31'd0, out_valid}, 32'd1);
        check(req, {24'd0, out_red}, {24'd0, er});
        check(req, {24'd0, out_green}, {24'd0, eg});
        check(req, {24'd0, out_blue}, {24'd0, eb});
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] hr;
        void'($urandom(32'h5EED_1234));
        rst = 1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        pix_data = 0; pix_valid = 0; pix_visible = 0; pix_underrun = 0;
        m_bm1 = 0; m_sel[0] = 0; m_sel[1] = 0; m_sel[2] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {out_red, out_green, out_blue}, 32'd0);
        check("R1", {31'd0, out_valid}, 32'd0);
        rst = 0;
        pix("R1 R6 defaults after reset", 32'hFFFF_FFFF, 1, 0);

        // R5 R9: 16-bit 5-6-5 layout
        wr(0, 32'h0000_0008);
        wr(1, 32'h0000_050B);
        wr(2, 32'h0000_0605);
        wr(3, 32'h0000_0500);
        pix("R9 all ones", 32'h0000_FFFF, 1, 0);
        pix("R5 pure red", 32'h0000_F800, 1, 0);
        pix("R9 replicate grey", 32'h0000_8410, 1, 0);
        check("R9", {24'd0, out_red}, 32'h84);
        check("R9", {24'd0, out_green}, 32'h82);

        // R2 R3: idle cycle holds components, valid drops
        hr = out_red;
        @(negedge clk); pix_data = 32'h0; pix_valid = 0; pix_visible = 1;
        @(negedge clk);
        check("R2", {31'd0, out_valid}, 32'd0);
        check("R3", {24'd0, out_red}, {24'd0, hr});

        // R7 R8 blanking and underrun, red fallback FF
        wr(1, 32'h00FF_050B);
        pix("R8 underrun", 32'h0000_07FF, 1, 1);
        check("R8", {24'd0, out_red}, 32'hFF);
        pix("R7 blanked", 32'h0000_07FF, 0, 0);

        // R4 byte masking: 1 byte, field in second byte
        wr(0, 32'h0);
        wr(1, 32'h0000_0808);
        pix("R4 masked byte", 32'h0000_ABCD, 1, 0);
        check("R4", {24'd0, out_red}, 32'h00);

        // R10 clamp, R11 past top, R9 length 3 and 1
        wr(0, 32'h0000_0018);
        wr(1, 32'h0000_0C00);
        wr(2, 32'h0000_081C);
        wr(3, 32'h0000_0300);
        pix("R10 R11 R9", 32'hF000_0ABD, 1, 0);
        check("R10", {24'd0, out_red}, 32'hAB);
        check("R11", {24'd0, out_green}, 32'h0F);
        check("R9", {24'd0, out_blue}, 32'hB6);
        wr(3, 32'h0000_0102);
        pix("R9 len1 one", 32'h0000_0004, 1, 0);
        check("R9", {24'd0, out_blue}, 32'hFF);
        wr(2, 32'h0033_0008);
        pix("R6 zero length", 32'hFFFF_FFFF, 1, 0);
        check("R6", {24'd0, out_green}, 32'h33);

        // R12: write and pixel on the same cycle
        wr(1, 32'h0000_0800);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 1; cfg_wdata = 32'h0011_0000;
        pix_data = 32'h55; pix_valid = 1; pix_visible = 1; pix_underrun = 0;
        @(negedge clk);
        cfg_we = 0; m_sel[0] = 32'h0011_0000;
        check("R12 old config", {24'd0, out_red}, 32'h55);
        @(negedge clk);
        pix_valid = 0;
        check("R12 new config", {24'd0, out_red}, 32'h11);

        // random mix
        for (int n = 0; n < 400; n++) begin
            if (n % 8 == 0) begin
                wr(2'($urandom_range(0, 3)), $urandom);
            end
            pix("R5 R9 R10 random", $urandom, ($urandom_range(0, 7) != 0),
                ($urandom_range(0, 9) == 0));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule